// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block holds the per-core record used by load-exclusive / store-exclusive synchronization. A load-exclusive marks a 32-byte aligned granule of the address space as reserved and moves the monitor from open to exclusive. A later store-exclusive succeeds only if the reservation is still live and covers the store address. The block gates the memory write of every store-exclusive and returns a one-bit status, 0 for success and 1 for failure. Software retries on 1.

The reservation is dropped by a clear-exclusive, by any exception entry or return, and by every accepted store-exclusive, whether it passed or failed. A clear-exclusive touches only this local record and causes no bus traffic. Exclusive accesses to shareable memory are marked exclusive on the bus. A shareable store-exclusive also needs a pass from the external global monitor, sampled in the cycle its write is accepted. Exclusive accesses to non-shareable memory go out as ordinary accesses.

The store-exclusive path uses valid/ready:
- The core raises `stx_valid` and must hold it, with `stx_addr` and `stx_shared`, until `stx_ready` is high.
- When the reservation hits, the write is requested on `mem_wr_req` and `stx_ready` follows `mem_wr_ready`. Back-pressure from memory therefore stalls the core.
- When the reservation misses, the write is suppressed and `stx_ready` is high at once.

Top module: `excl_mon`

## Requirements
- R1: Out of reset the monitor is open: a store-exclusive issued before any load-exclusive raises no `mem_wr_req` and reports `stat_fail`=1.
- R2: After a load-exclusive, a store-exclusive to the same address raises `mem_wr_req`. One cycle after its handshake, `stat_valid`=1 and `stat_fail`=0 (non-shareable case).
- R3: Matching uses address bits above bit 4, a 32-byte granule. A different byte offset in the same granule hits. An address in another granule misses: no `mem_wr_req`, `stx_ready`=1 in the same cycle, and `stat_fail`=1.
- R4: Every accepted store-exclusive drops the reservation, pass or fail, so an immediately repeated store-exclusive fails.
- R5: `clr_excl` returns the monitor to open, so a following store-exclusive fails. A cycle with only `clr_excl` shows `mem_wr_req`=0 and `bus_excl`=0.
- R6: `exc_event` (exception entry or return) drops the reservation, so a store-exclusive after it fails, even one that was stalled across it.
- R7: When `ldx_valid` coincides with `clr_excl`, `exc_event` or an accepted store-exclusive, the load-exclusive wins and the monitor is exclusive on the new address.
- R8: `bus_excl` is 1 exactly when a shareable load-exclusive is presented, or a shareable store-exclusive write is requested. Non-shareable accesses are never marked.
- R9: A hitting shareable store-exclusive reports `stat_fail`=0 only if `gmon_pass`=1 in its handshake cycle. Otherwise it reports 1, although its write was issued.
- R10: While a hitting store-exclusive waits on `mem_wr_ready`=0, `stx_ready` is 0, the reservation is held and no status is produced.
- R11: `stat_valid` pulses for exactly one cycle, the cycle after each store-exclusive handshake, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive presented this cycle |
| ldx_addr | input | AW | Load-exclusive address |
| ldx_shared | input | 1 | Load-exclusive address is shareable |
| clr_excl | input | 1 | Clear-exclusive executed |
| exc_event | input | 1 | Exception entry or return |
| stx_valid | input | 1 | Store-exclusive request valid |
| stx_ready | output | 1 | Store-exclusive accepted this cycle |
| stx_addr | input | AW | Store-exclusive address |
| stx_shared | input | 1 | Store-exclusive address is shareable |
| mem_wr_ready | input | 1 | Memory accepts the requested write |
| gmon_pass | input | 1 | Global monitor pass for the current shareable write |
| mem_wr_req | output | 1 | Store-exclusive write requested on the bus |
| bus_excl | output | 1 | Current bus access is marked exclusive |
| stat_valid | output | 1 | Store-exclusive status valid |
| stat_fail | output | 1 | Status: 0 success, 1 failure |

## Verification
Several events can land in one cycle:
- a store-exclusive handshake together with a load-exclusive;
- a clear-exclusive or exception event together with a load-exclusive;
- an exception arriving while a store-exclusive is stalled by memory back-pressure.

Directed steps force each overlap. Random traffic, which keeps a small set of granules so hits are frequent, produces them again many times. Each cycle is judged against a bench model that applies the load-exclusive-first rule. The model's predicted next-cycle status shows which event took effect.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic {MON_OPEN = 1'b0, MON_EXCL = 1'b1} mon_state_e;
endpackage

// File: rtl/excl_match.sv
module excl_match #(
  parameter int AW = 32,
  parameter int GB = 5
) (
  input  logic          live,
  input  logic [AW-1:0] tag_addr,
  input  logic [AW-1:0] probe_addr,
  output logic          hit
);
  generate
    if (GB == 0) begin : g_exact
      assign hit = live && (tag_addr == probe_addr);
    end else begin : g_granule
      assign hit = live && (tag_addr[AW-1:GB] == probe_addr[AW-1:GB]);
    end
  endgenerate
endmodule

// File: rtl/excl_tag.sv
module excl_tag #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          drop,
  output excl_pkg::mon_state_e state,
  output logic [AW-1:0] tag_addr
);
  import excl_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= MON_OPEN;
      tag_addr <= '0;
    end else if (set) begin
      state    <= MON_EXCL;
      tag_addr <= set_addr;
    end else if (drop) begin
      state    <= MON_OPEN;
    end
  end
endmodule

// File: rtl/excl_status.sv
module excl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic pass,
  output logic stat_valid,
  output logic stat_fail
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_fail  <= 1'b0;
    end else begin
      stat_valid <= fire;
      stat_fail  <= fire ? !pass : 1'b0;
    end
  end
endmodule

// File: rtl/excl_mon.sv
module excl_mon #(
  parameter int AW         = 32,
  parameter int GRAN_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldx_valid,
  input  logic [AW-1:0] ldx_addr,
  input  logic          ldx_shared,
  input  logic          clr_excl,
  input  logic          exc_event,
  input  logic          stx_valid,
  output logic          stx_ready,
  input  logic [AW-1:0] stx_addr,
  input  logic          stx_shared,
  input  logic          mem_wr_ready,
  input  logic          gmon_pass,
  output logic          mem_wr_req,
  output logic          bus_excl,
  output logic          stat_valid,
  output logic          stat_fail
);
  import excl_pkg::*;
  localparam int GB = $clog2(GRAN_BYTES);

  mon_state_e    state;
  logic [AW-1:0] tag_addr;
  logic          tag_live;
  logic          hit;
  logic          fire;
  logic          pass;

  assign tag_live = (state == MON_EXCL);

  excl_tag #(.AW(AW)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .set(ldx_valid), .set_addr(ldx_addr),
    .drop(clr_excl || exc_event || fire),
    .state(state), .tag_addr(tag_addr)
  );

  excl_match #(.AW(AW), .GB(GB)) u_match (
    .live(tag_live), .tag_addr(tag_addr), .probe_addr(stx_addr), .hit(hit)
  );

  // a miss completes at once with the write suppressed
  assign stx_ready  = hit ? mem_wr_ready : 1'b1;
  assign fire       = stx_valid && stx_ready;
  assign mem_wr_req = stx_valid && hit;
  assign pass       = hit && (!stx_shared || gmon_pass);
  assign bus_excl   = (ldx_valid && ldx_shared) || (mem_wr_req && stx_shared);

  excl_status u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pass(pass),
    .stat_valid(stat_valid), .stat_fail(stat_fail)
  );
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic ldx_valid,
  input logic ldx_shared,
  input logic clr_excl,
  input logic exc_event,
  input logic stx_valid,
  input logic stx_ready,
  input logic stx_shared,
  input logic mem_wr_ready,
  input logic gmon_pass,
  input logic mem_wr_req,
  input logic bus_excl,
  input logic stat_valid,
  input logic stat_fail,
  input logic tag_live
);
  p_open_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_valid && !tag_live) |-> !mem_wr_req);
  p_stx_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_valid && stx_ready && !ldx_valid) |=> !tag_live);
  p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_excl && !ldx_valid) |=> !tag_live);
  p_exc_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_event && !ldx_valid) |=> !tag_live);
  p_ldx_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_valid |=> tag_live);
  p_bus_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_excl |-> ((ldx_valid && ldx_shared) || (mem_wr_req && stx_shared)));
  p_gmon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_fail) |-> $past(!stx_shared || gmon_pass));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ready) |-> !stx_ready);
  p_stat_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(stx_valid && stx_ready));
endmodule

bind excl_mon excl_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ldx_valid(ldx_valid), .ldx_shared(ldx_shared),
  .clr_excl(clr_excl), .exc_event(exc_event), .stx_valid(stx_valid),
  .stx_ready(stx_ready), .stx_shared(stx_shared), .mem_wr_ready(mem_wr_ready),
  .gmon_pass(gmon_pass), .mem_wr_req(mem_wr_req), .bus_excl(bus_excl),
  .stat_valid(stat_valid), .stat_fail(stat_fail), .tag_live(tag_live)
);

// File: tb/excl_mon_test.sv
module excl_mon_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ldx_valid = 0, ldx_shared = 0, clr_excl = 0, exc_event = 0;
  logic        stx_valid = 0, stx_shared = 0, mem_wr_ready = 0, gmon_pass = 0;
  logic [31:0] ldx_addr = '0, stx_addr = '0;
  logic        stx_ready, mem_wr_req, bus_excl, stat_valid, stat_fail;

  int n_run = 0, n_fail = 0;
  bit m_excl = 0;
  logic [26:0] m_tag = '0;
  bit pend = 0;

  always #5 clk = ~clk;

  excl_mon uut (
    .clk(clk), .rst_n(rst_n), .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
    .ldx_shared(ldx_shared), .clr_excl(clr_excl), .exc_event(exc_event),
    .stx_valid(stx_valid), .stx_ready(stx_ready), .stx_addr(stx_addr),
    .stx_shared(stx_shared), .mem_wr_ready(mem_wr_ready), .gmon_pass(gmon_pass),
    .mem_wr_req(mem_wr_req), .bus_excl(bus_excl), .stat_valid(stat_valid),
    .stat_fail(stat_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit f_hit(input logic [31:0] a);
    return m_excl && (m_tag == a[31:5]);
  endfunction

  // one cycle: drive, check combinational outputs, clock, check status
  task automatic step(input string req, input bit lv, input logic [31:0] la,
                      input bit lsh, input bit clr, input bit exc, input bit sv,
                      input logic [31:0] sa, input bit ssh, input bit mr,
                      input bit gp);
    bit h, rdy, fire, ps, bx;
    @(negedge clk);
    ldx_valid = lv; ldx_addr = la; ldx_shared = lsh; clr_excl = clr;
    exc_event = exc; stx_valid = sv; stx_addr = sa; stx_shared = ssh;
    mem_wr_ready = mr; gmon_pass = gp;
    #2;
    h    = f_hit(sa);
    rdy  = h ? mr : 1'b1;
    fire = sv && rdy;
    ps   = h && (!ssh || gp);
    bx   = (lv && lsh) || (sv && h && ssh);
    chk(mem_wr_req == (sv && h), req, "mem_wr_req", mem_wr_req, sv && h);
    chk(bus_excl == bx, req, "bus_excl", bus_excl, bx);
    if (sv) chk(stx_ready == rdy, req, "stx_ready", stx_ready, rdy);
    @(posedge clk);
    #1;
    chk(stat_valid == fire, req, "stat_valid", stat_valid, fire);
    if (fire) chk(stat_fail == !ps, req, "stat_fail", stat_fail, !ps);
    if (lv) begin m_excl = 1; m_tag = la[31:5]; end
    else if (clr || exc || fire) m_excl = 0;
    pend = sv && !fire;
  endtask

  task automatic idle();
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] sa_h;
    bit ssh_h;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(stat_valid == 0, "R11", "reset stat_valid", stat_valid, 0);
    @(negedge clk); rst_n = 1;
    // R1: store with monitor open
    step("R1", 0, 0, 0, 0, 0, 1, 32'h100, 0, 1, 1);
    // R2: pass
    step("R2", 1, 32'h200, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R2", 0, 0, 0, 0, 0, 1, 32'h200, 0, 1, 0);
    // R4: repeat fails
    step("R4", 0, 0, 0, 0, 0, 1, 32'h200, 0, 1, 1);
    // R3: same granule, other offset; then other granule
    step("R3", 1, 32'h300, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R3", 0, 0, 0, 0, 0, 1, 32'h31C, 0, 1, 0);
    step("R3", 1, 32'h300, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R3", 0, 0, 0, 0, 0, 1, 32'h320, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 32'h300, 0, 1, 0);
    // R5: clear-exclusive
    step("R5", 1, 32'h400, 1, 0, 0, 0, 0, 0, 1, 1);
    step("R5", 0, 0, 0, 1, 0, 0, 0, 0, 1, 1);
    step("R5", 0, 0, 0, 0, 0, 1, 32'h400, 1, 1, 1);
    // R6: exception while stalled
    step("R6", 1, 32'h500, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R10", 0, 0, 0, 0, 0, 1, 32'h500, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 1, 32'h500, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 1, 32'h500, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 1, 32'h500, 0, 0, 1);
    // R7: load wins over clear, exception, store handshake
    step("R7", 1, 32'h600, 0, 1, 1, 0, 0, 0, 1, 1);
    step("R7", 1, 32'h640, 0, 0, 0, 1, 32'h600, 0, 1, 1);
    step("R7", 0, 0, 0, 0, 0, 1, 32'h640, 0, 1, 1);
    // R8 / R9: shareable with global monitor
    step("R8", 1, 32'h700, 1, 0, 0, 0, 0, 0, 1, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 32'h700, 1, 1, 0);
    step("R8", 1, 32'h700, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 32'h704, 1, 1, 1);
    idle();
    // random traffic over four granules
    sa_h = '0; ssh_h = 0;
    for (int i = 0; i < 3000; i++) begin
      bit lv, clr, exc, sv, mr, gp, lsh;
      logic [31:0] la;
      lv  = ($urandom % 5) == 0;
      la  = {25'd0, 2'($urandom % 4), 5'($urandom)};
      lsh = $urandom % 2;
      clr = ($urandom % 16) == 0;
      exc = ($urandom % 16) == 0;
      mr  = ($urandom % 3) != 0;
      gp  = ($urandom % 4) != 0;
      if (pend) sv = 1;
      else begin
        sv    = ($urandom % 5) < 2;
        sa_h  = {25'd0, 2'($urandom % 4), 5'($urandom)};
        ssh_h = $urandom % 2;
      end
      step("R11", lv, la, lsh, clr, exc, sv, sa_h, ssh_h, mr, gp);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule